// File: doc/BRIEF.md
# Floating-Point Exception Flag Classifier

This block sits beside a single-precision floating-point unit and decides which exception conditions one operation raises. It takes an operation code, both 32-bit operands and the raw 32-bit result the arithmetic unit produced, plus a valid strobe. It does no arithmetic of its own. It looks at the bit patterns of the three words and reports five flags: underflow, overflow, divide-by-zero, illegal operation and denormal operand. It also reports an any-exception request.

The flag rules are deliberately nonstandard. Overflow means the result came back as a NaN. Underflow means the result is denormal. A denormal operand gets its own flag. Divide-by-zero is suppressed when the dividend is infinite.

Every output is registered. The outputs carry the verdict for exactly one clock after the cycle in which valid was high, and are zero in every other cycle. The surrounding pipeline samples them one stage after issuing the operation.

Top module: `fpxFlagTop`

## Requirements
- R1: All six outputs are registered. They show the verdict in the cycle after inValid is high, and are zero in any cycle whose preceding cycle had inValid low.
- R2: Underflow is set when the result has an all-zero exponent and a nonzero fraction (a denormal result).
- R3: Overflow is set when the result is a NaN: an all-ones exponent with a nonzero fraction, quiet or signaling.
- R4: Divide-by-zero is set for opcode divide (3'd3) when operand B, the divisor, is zero and operand A is not infinite.
- R5: Illegal operation is set, for every opcode, when either operand is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and fraction bit 22 clear.
- R6: Illegal operation is set for an effective subtraction of two infinities. This is opcode add (3'd0) with infinities of opposite sign, or opcode subtract (3'd1) with infinities of the same sign.
- R7: Illegal operation is set for opcode multiply (3'd2) when one operand is zero and the other is infinite.
- R8: Illegal operation is set for opcode divide when both operands are zero, or both are infinite.
- R9: Denormal operand is set when operand A or operand B has an all-zero exponent and a nonzero fraction, for every opcode.
- R10: anyExc is high in exactly the cycles in which at least one of the five flags is high.
- R11: The sign bit has no effect on whether a word counts as zero or infinity. Opcodes compare (3'd4) and 5 to 7 raise only the R2, R3, R5 and R9 conditions.
- R12: During and straight after an active-low reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | 0 add, 1 subtract, 2 multiply, 3 divide, 4 compare, 5-7 other |
| opA | input | 32 | First operand (dividend for divide) |
| opB | input | 32 | Second operand (divisor for divide) |
| rawResult | input | 32 | Result word from the arithmetic unit |
| flagUnderflow | output | 1 | Denormal result |
| flagOverflow | output | 1 | NaN result |
| flagDivZero | output | 1 | Division by zero |
| flagIllegal | output | 1 | Signaling NaN or invalid infinity/zero combination |
| flagDenormal | output | 1 | Denormal operand |
| anyExc | output | 1 | OR of the five flags |

## Verification
A wrong operand class or a mis-decoded opcode strobe shows up as a single wrong flag in the cycle after the valid strobe. Nothing persists, so each mistake is visible at once and only for that one cycle. A capture register that fails to clear would instead leave a flag standing in the following idle cycle. The bench therefore sweeps every combination of special values, opcodes and result classes. It checks each verdict cycle and the idle cycle after it, with garbage on the inputs during the idle cycle.

// File: rtl/fpxPkg.sv
package fpxPkg;
  localparam logic [2:0] OPC_ADD = 3'd0;
  localparam logic [2:0] OPC_SUB = 3'd1;
  localparam logic [2:0] OPC_MUL = 3'd2;
  localparam logic [2:0] OPC_DIV = 3'd3;
  localparam logic [2:0] OPC_CMP = 3'd4;

  typedef struct packed {
    logic sign;
    logic isZero;
    logic isInf;
    logic isNan;
    logic isSnan;
    logic isDenorm;
  } wordClass_t;

  typedef struct packed {
    logic capture;
    logic addSub;
    logic negate;
    logic mulOp;
    logic divOp;
  } ctrlStrobe_t;

  typedef struct packed {
    logic underflow;
    logic overflow;
    logic divZero;
    logic illegal;
    logic denormal;
  } excFlags_t;
endpackage

// File: rtl/fpxClassify.sv
module fpxClassify
  import fpxPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output wordClass_t            cls
);
  localparam int QBIT = FRAC_W - 1;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic expOnes, expZero, fracZero;

  always_comb begin
    expField  = word[EXP_W+FRAC_W-1:FRAC_W];
    fracField = word[FRAC_W-1:0];
    expOnes   = &expField;
    expZero   = ~|expField;
    fracZero  = ~|fracField;
    cls.sign     = word[EXP_W+FRAC_W];
    cls.isZero   = expZero & fracZero;
    cls.isDenorm = expZero & ~fracZero;
    cls.isInf    = expOnes & fracZero;
    cls.isNan    = expOnes & ~fracZero;
    cls.isSnan   = expOnes & ~fracZero & ~fracField[QBIT];
  end

  always_comb begin
    assert_class_exclusive_R11: assert ($onehot0({cls.isZero, cls.isDenorm, cls.isInf, cls.isNan}));
  end
endmodule

// File: rtl/fpxControl.sv
module fpxControl
  import fpxPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  opCode,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.capture = inValid;
    strobe.addSub  = inValid & ((opCode == OPC_ADD) | (opCode == OPC_SUB));
    strobe.negate  = inValid & (opCode == OPC_SUB);
    strobe.mulOp   = inValid & (opCode == OPC_MUL);
    strobe.divOp   = inValid & (opCode == OPC_DIV);
  end

  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.addSub, strobe.mulOp, strobe.divOp}));
  assert_strobe_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |-> !(strobe.addSub | strobe.mulOp | strobe.divOp));
endmodule

// File: rtl/fpxDatapath.sv
module fpxDatapath
  import fpxPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [EXP_W+FRAC_W:0] rawResult,
  output excFlags_t             flags,
  output logic                  anyExc
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int N_WORDS = 3;

  logic [WORD_W-1:0] words [N_WORDS];
  wordClass_t        cls   [N_WORDS];

  always_comb begin
    words[0] = opA;
    words[1] = opB;
    words[2] = rawResult;
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : gClass
    fpxClassify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uClass (
      .word(words[i]),
      .cls (cls[i])
    );
  end

  wordClass_t clsA, clsB, clsR;
  excFlags_t  nextFlags;
  logic       infMinusInf, zeroTimesInf, badDivide;

  always_comb begin
    clsA = cls[0];
    clsB = cls[1];
    clsR = cls[2];
    infMinusInf  = strobe.addSub & clsA.isInf & clsB.isInf &
                   (clsA.sign ^ clsB.sign ^ strobe.negate);
    zeroTimesInf = strobe.mulOp & ((clsA.isZero & clsB.isInf) | (clsA.isInf & clsB.isZero));
    badDivide    = strobe.divOp & ((clsA.isZero & clsB.isZero) | (clsA.isInf & clsB.isInf));
    nextFlags.underflow = clsR.isDenorm;
    nextFlags.overflow  = clsR.isNan;
    nextFlags.divZero   = strobe.divOp & clsB.isZero & ~clsA.isInf;
    nextFlags.illegal   = clsA.isSnan | clsB.isSnan | infMinusInf | zeroTimesInf | badDivide;
    nextFlags.denormal  = clsA.isDenorm | clsB.isDenorm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      anyExc <= 1'b0;
    end else if (strobe.capture) begin
      flags  <= nextFlags;
      anyExc <= |nextFlags;
    end else begin
      flags  <= '0;
      anyExc <= 1'b0;
    end
  end

  assert_any_matches_R10: assert property (@(posedge clk) disable iff (!rstN)
    anyExc == (|flags));
  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> (flags == '0) && !anyExc);
  assert_divzero_needs_div_R4: assert property (@(posedge clk) disable iff (!rstN)
    flags.divZero |-> $past(strobe.divOp));
  assert_underflow_denorm_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && clsR.isDenorm) |=> flags.underflow);
  assert_overflow_nan_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && clsR.isNan) |=> flags.overflow);
endmodule

// File: rtl/fpxFlagTop.sv
module fpxFlagTop
  import fpxPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [2:0]            opCode,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [EXP_W+FRAC_W:0] rawResult,
  output logic                  flagUnderflow,
  output logic                  flagOverflow,
  output logic                  flagDivZero,
  output logic                  flagIllegal,
  output logic                  flagDenormal,
  output logic                  anyExc
);
  ctrlStrobe_t strobe;
  excFlags_t   flags;

  fpxControl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .opCode (opCode),
    .strobe (strobe)
  );

  fpxDatapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .rawResult(rawResult),
    .flags    (flags),
    .anyExc   (anyExc)
  );

  always_comb begin
    flagUnderflow = flags.underflow;
    flagOverflow  = flags.overflow;
    flagDivZero   = flags.divZero;
    flagIllegal   = flags.illegal;
    flagDenormal  = flags.denormal;
  end

  assert_reset_quiet_R12: assert property (@(posedge clk)
    !rstN |=> !anyExc);
  assert_flags_follow_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    anyExc |-> $past(inValid));
endmodule

// File: tb/sim_fpxFlagTop.sv
module sim_fpxFlagTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [31:0] opA = '0, opB = '0, rawResult = '0;
  logic flagUnderflow, flagOverflow, flagDivZero, flagIllegal, flagDenormal, anyExc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpxFlagTop u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .opA(opA), .opB(opB), .rawResult(rawResult),
    .flagUnderflow(flagUnderflow), .flagOverflow(flagOverflow),
    .flagDivZero(flagDivZero), .flagIllegal(flagIllegal),
    .flagDenormal(flagDenormal), .anyExc(anyExc)
  );

  localparam int N_VALS = 10;
  function automatic logic [31:0] pick(int k);
    case (k)
      0: return 32'h0000_0000;  // +0
      1: return 32'h8000_0000;  // -0
      2: return 32'h7F80_0000;  // +inf
      3: return 32'hFF80_0000;  // -inf
      4: return 32'h7FC0_0001;  // quiet NaN
      5: return 32'h7F80_0001;  // signaling NaN
      6: return 32'h0000_0123;  // +denormal
      7: return 32'h8040_0000;  // -denormal
      8: return 32'h3F80_0000;  // 1.0
      default: return 32'hFFA0_0000; // negative signaling NaN
    endcase
  endfunction

  function automatic bit isZ(logic [31:0] w);  return w[30:0] == 0; endfunction
  function automatic bit isI(logic [31:0] w);  return w[30:23] == 8'hFF && w[22:0] == 0; endfunction
  function automatic bit isN(logic [31:0] w);  return w[30:23] == 8'hFF && w[22:0] != 0; endfunction
  function automatic bit isS(logic [31:0] w);  return isN(w) && !w[22]; endfunction
  function automatic bit isD(logic [31:0] w);  return w[30:23] == 0 && w[22:0] != 0; endfunction

  task automatic check1(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h r=%h got=%b exp=%b", req, opCode, opA, opB, rawResult, got, exp);
    end
  endtask

  task automatic runVec(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] r);
    bit eU, eO, eZ, eI, eN, eAny;
    bit zA, zB, iA, iB;
    zA = isZ(a); zB = isZ(b); iA = isI(a); iB = isI(b);
    @(negedge clk);
    inValid = 1'b1; opCode = op; opA = a; opB = b; rawResult = r;
    eU = isD(r);                                   // R2
    eO = isN(r);                                   // R3
    eZ = (op == 3'd3) && zB && !iA;                // R4, R11 sign ignored
    eI = isS(a) || isS(b);                         // R5
    if (op == 3'd0 && iA && iB && (a[31] != b[31])) eI = 1;  // R6
    if (op == 3'd1 && iA && iB && (a[31] == b[31])) eI = 1;  // R6
    if (op == 3'd2 && ((zA && iB) || (iA && zB))) eI = 1;     // R7
    if (op == 3'd3 && ((zA && zB) || (iA && iB))) eI = 1;     // R8
    eN = isD(a) || isD(b);                         // R9
    eAny = eU | eO | eZ | eI | eN;
    @(negedge clk);
    check1("R2", flagUnderflow, eU);
    check1("R3", flagOverflow, eO);
    check1("R4", flagDivZero, eZ);
    check1(op >= 3'd4 ? "R11" : (op == 3'd2 ? "R7" : (op == 3'd3 ? "R8" : "R6")), flagIllegal, eI);
    check1("R9", flagDenormal, eN);
    check1("R10", anyExc, eAny);
    inValid = 1'b0; opCode = 3'd3; opA = 32'h7F80_0001; opB = 32'h0000_0000; rawResult = 32'h0000_0001;
    @(negedge clk);
    check1("R1", anyExc | flagUnderflow | flagOverflow | flagDivZero | flagIllegal | flagDenormal, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    inValid = 1'b1; opCode = 3'd3; opA = 32'h7F80_0001; opB = 32'h0; rawResult = 32'h1;
    repeat (3) @(negedge clk);
    check1("R12", anyExc | flagIllegal | flagDivZero | flagUnderflow, 1'b0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check1("R12", anyExc, 1'b0);
    for (int op = 0; op < 8; op++)
      for (int ka = 0; ka < N_VALS; ka++)
        for (int kb = 0; kb < N_VALS; kb++)
          for (int kr = 4; kr < 9; kr++)
            runVec(op[2:0], pick(ka), pick(kb), pick(kr));
    // back-to-back valid: second verdict replaces the first (R1)
    @(negedge clk);
    inValid = 1'b1; opCode = 3'd3; opA = 32'h3F80_0000; opB = 32'h8000_0000; rawResult = 32'h7F80_0000;
    @(negedge clk);
    check1("R4", flagDivZero, 1'b1);
    opCode = 3'd2; opA = 32'h3F80_0000; opB = 32'h3F80_0000;
    @(negedge clk);
    check1("R1", flagDivZero | anyExc, 1'b0);
    inValid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule